// File: doc/BRIEF.md
# TLB Mirror Register Interface

This block sits between a processor's special-register access path and a small TLB that software loads and reads back itself. Software never addresses a TLB entry directly. It writes a selector register to choose one set and one entry, then uses two mirror registers, a high word and a low word, as the window onto that entry. A write to the low mirror commits the entry. A read of any special register refreshes both mirrors from the selected entry before the read data is produced.

There are four banks of sixteen 32-bit special registers, and the active bank is chosen by a 2-bit input. Only banks 1 and 2 are backed by a TLB, and each owns its own array of 4 sets by 16 entries. A write to the high mirror also copies its value into a fault-cause register. A commit takes its high word from that fault-cause register. If a commit overwrites an entry that was valid, the block emits a one-cycle invalidate request carrying the old virtual page number, so that cached translations of that page can be dropped.

Top module: `tlb_mirror_regs`

## Requirements
- R1: After reset, read data is zero, no invalidate request is pending, and every special register and every TLB entry word reads as zero.
- R2: A write stores the data in register `regNum` of the bank named by `bankSel`. Each of the four banks keeps its own 16 registers, and a later read of the same bank and register returns the stored value.
- R3: In the selector register (register 4), bits [3:0] pick the entry (0 to 15) and bits [5:4] pick the set (0 to 3). Bank 1 uses TLB array 0 and bank 2 uses TLB array 1, so equal selectors in different banks or different sets address different entries.
- R4: While bank 1 or 2 is active, a write to the high mirror (register 6) also stores the same value in the fault-cause register (register 3) of that bank.
- R5: While bank 1 or 2 is active, a write to the low mirror (register 5) sets the selected entry's low word to the write data and its high word to the bank's current fault-cause register value.
- R6: When a commit (R5) overwrites an entry whose low word has bit 3 set, `invReq` is 1 during exactly the one cycle after the write, and `invVpn` holds bits [31:13] of the old high word. If bit 3 of the old low word was 0, `invReq` stays 0.
- R7: A read while bank 1 or 2 is active first loads registers 5 and 6 of that bank from the selected entry's low and high words. Reading register 5 or 6 therefore returns the entry's words, not the value last written to them.
- R8: In banks 0 and 3, registers 5 and 6 are plain storage. Writing them copies nothing to register 3, commits no entry and raises no invalidate request, and reads do not refresh them.
- R9: `rdata` changes only in the cycle after a cycle with `regRd` high and holds its value otherwise. When `regWe` and `regRd` are both high, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bankSel | input | 2 | Active register bank (0 to 3) |
| regWe | input | 1 | Write strobe for `regNum` |
| regRd | input | 1 | Read strobe for `regNum` |
| regNum | input | 4 | Special register number |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after `regRd` |
| invReq | output | 1 | One-cycle page invalidate request |
| invVpn | output | 19 | Virtual page number of the overwritten valid entry |

## Verification
A table of load sequences (select, high, low) is applied in both TLB banks. The sequences place equal selectors in both banks and use the corner slots 0x00 and 0x3F. Some commits overwrite a valid entry, some overwrite an invalid one, and some write an entry whose own valid bit is clear. Together these separate the bank-to-array mapping, the set and entry decode, and whether the invalidate follows the old valid bit or the new one. Directed sequences then cover the following:
- writing a junk value to a mirror and reading it back, which shows that reads return the entry and not the stale mirror;
- mirror writes in banks 0 and 3, which show that those banks stay plain storage;
- a write and a read in the same cycle, which shows that the write wins and the read data is held.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

  // Decoded strobes passed from the control to the datapath.
  typedef struct packed {
    logic       wrReg;    // store wdata into bank/regNum
    logic       wrHi;     // high mirror write in a TLB-backed bank
    logic       wrLo;     // low mirror write: commit the selected entry
    logic       rdReq;    // accepted read (no write in the same cycle)
    logic       refresh;  // read in a TLB-backed bank: reload the mirrors
    logic [1:0] bank;     // active register bank
    logic       tlbBank;  // TLB array of the active bank (bank 1 -> 0, bank 2 -> 1)
  } tlbm_strobe_t;

endpackage

// File: rtl/tlbm_ctrl.sv
module tlbm_ctrl
  import tlbm_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int REG_LO = 5,
  parameter int REG_HI = 6
) (
  input  logic [1:0]       bankSel,
  input  logic             regWe,
  input  logic             regRd,
  input  logic [REG_W-1:0] regNum,
  output tlbm_strobe_t     st
);

  localparam logic [REG_W-1:0] NUM_LO = REG_W'(REG_LO);
  localparam logic [REG_W-1:0] NUM_HI = REG_W'(REG_HI);

  logic tlbActive;

  // Only banks 1 and 2 own a TLB array.
  assign tlbActive = (bankSel == 2'd1) || (bankSel == 2'd2);

  always_comb begin
    st.wrReg   = regWe;
    st.wrHi    = regWe && tlbActive && (regNum == NUM_HI);
    st.wrLo    = regWe && tlbActive && (regNum == NUM_LO);
    // A write in the same cycle takes precedence over a read.
    st.rdReq   = regRd && !regWe;
    st.refresh = regRd && !regWe && tlbActive;
    st.bank    = bankSel;
    st.tlbBank = bankSel[1];
  end

endmodule

// File: rtl/tlbm_datapath.sv
module tlbm_datapath
  import tlbm_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_REGS    = 16,
  parameter int NUM_SETS    = 4,
  parameter int NUM_ENTRIES = 16,
  parameter int REG_CAUSE   = 3,
  parameter int REG_SEL     = 4,
  parameter int REG_LO      = 5,
  parameter int REG_HI      = 6,
  parameter int VPN_LSB     = 13,
  parameter int VALID_BIT   = 3,
  localparam int REG_W      = $clog2(NUM_REGS),
  localparam int VPN_W      = DATA_W - VPN_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tlbm_strobe_t      st,
  input  logic [REG_W-1:0]  regNum,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              invReq,
  output logic [VPN_W-1:0]  invVpn
);

  localparam int IDX_W     = $clog2(NUM_ENTRIES);
  localparam int SET_W     = $clog2(NUM_SETS);
  localparam int SLOT_W    = IDX_W + SET_W;
  localparam int SLOTS     = NUM_SETS * NUM_ENTRIES;
  localparam int NUM_BANKS = 4;
  localparam int TLB_BANKS = 2;
  localparam logic [REG_W-1:0] NUM_LO = REG_W'(REG_LO);
  localparam logic [REG_W-1:0] NUM_HI = REG_W'(REG_HI);

  // Banked special registers
  logic [DATA_W-1:0] sregs [NUM_BANKS][NUM_REGS];

  // Selector: low IDX_W bits = entry, next SET_W bits = set
  logic [SLOT_W-1:0] slot;
  assign slot = sregs[st.bank][REG_SEL][SLOT_W-1:0];

  // Selected entry of each TLB array, then of the active one
  logic [TLB_BANKS-1:0][DATA_W-1:0] bankHi;
  logic [TLB_BANKS-1:0][DATA_W-1:0] bankLo;
  logic [DATA_W-1:0] selHi;
  logic [DATA_W-1:0] selLo;

  assign selHi = bankHi[st.tlbBank];
  assign selLo = bankLo[st.tlbBank];

  for (genvar g = 0; g < TLB_BANKS; g++) begin : gTlb
    logic [DATA_W-1:0] hiMem [SLOTS];
    logic [DATA_W-1:0] loMem [SLOTS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int s = 0; s < SLOTS; s++) begin
          hiMem[s] <= '0;
          loMem[s] <= '0;
        end
      end else if (st.wrLo && (st.tlbBank == 1'(g))) begin
        loMem[slot] <= wdata;
        hiMem[slot] <= sregs[st.bank][REG_CAUSE];
      end
    end

    assign bankHi[g] = hiMem[slot];
    assign bankLo[g] = loMem[slot];
  end

  // Register file with the mirror side effects
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        for (int r = 0; r < NUM_REGS; r++) begin
          sregs[b][r] <= '0;
        end
      end
    end else begin
      if (st.wrReg) sregs[st.bank][regNum] <= wdata;
      if (st.wrHi)  sregs[st.bank][REG_CAUSE] <= wdata;
      if (st.refresh) begin
        sregs[st.bank][REG_LO] <= selLo;
        sregs[st.bank][REG_HI] <= selHi;
      end
    end
  end

  // Read data: mirrors see the refreshed entry words
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (st.rdReq) begin
      if (st.refresh && regNum == NUM_LO)      rdata <= selLo;
      else if (st.refresh && regNum == NUM_HI) rdata <= selHi;
      else                                      rdata <= sregs[st.bank][regNum];
    end
  end

  // Invalidate request for an overwritten valid entry
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      invReq <= 1'b0;
      invVpn <= '0;
    end else begin
      invReq <= st.wrLo && selLo[VALID_BIT];
      if (st.wrLo && selLo[VALID_BIT]) invVpn <= selHi[DATA_W-1:VPN_LSB];
    end
  end

  // R6: an invalidate only ever follows a commit
  a_r6_inv_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    invReq |-> $past(st.wrLo));

  // R4: a high-mirror write lands in the fault-cause register
  a_r4_cause_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st.wrHi) |-> (sregs[$past(st.bank)][REG_CAUSE] == $past(wdata)));

  // R7: a refreshed low-mirror read returns what the mirror now holds
  a_r7_read_matches_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st.refresh) && $past(regNum) == NUM_LO) |->
      (rdata == sregs[$past(st.bank)][REG_LO]));

  // R9: read data holds when no read was accepted
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(st.rdReq) |-> (rdata == $past(rdata)));

endmodule

// File: rtl/tlb_mirror_regs.sv
module tlb_mirror_regs
  import tlbm_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_REGS    = 16,
  parameter int NUM_SETS    = 4,
  parameter int NUM_ENTRIES = 16,
  parameter int REG_CAUSE   = 3,
  parameter int REG_SEL     = 4,
  parameter int REG_LO      = 5,
  parameter int REG_HI      = 6,
  parameter int VPN_LSB     = 13,
  parameter int VALID_BIT   = 3,
  localparam int REG_W      = $clog2(NUM_REGS),
  localparam int VPN_W      = DATA_W - VPN_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bankSel,
  input  logic              regWe,
  input  logic              regRd,
  input  logic [REG_W-1:0]  regNum,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              invReq,
  output logic [VPN_W-1:0]  invVpn
);

  tlbm_strobe_t st;

  tlbm_ctrl #(
    .REG_W (REG_W),
    .REG_LO(REG_LO),
    .REG_HI(REG_HI)
  ) uCtrl (
    .bankSel(bankSel),
    .regWe  (regWe),
    .regRd  (regRd),
    .regNum (regNum),
    .st     (st)
  );

  tlbm_datapath #(
    .DATA_W     (DATA_W),
    .NUM_REGS   (NUM_REGS),
    .NUM_SETS   (NUM_SETS),
    .NUM_ENTRIES(NUM_ENTRIES),
    .REG_CAUSE  (REG_CAUSE),
    .REG_SEL    (REG_SEL),
    .REG_LO     (REG_LO),
    .REG_HI     (REG_HI),
    .VPN_LSB    (VPN_LSB),
    .VALID_BIT  (VALID_BIT)
  ) uDp (
    .clk   (clk),
    .rst_n (rst_n),
    .st    (st),
    .regNum(regNum),
    .wdata (wdata),
    .rdata (rdata),
    .invReq(invReq),
    .invVpn(invVpn)
  );

endmodule

// File: tb/tb_tlb_mirror_regs.sv
module tb_tlb_mirror_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bankSel = '0;
  logic        regWe = 1'b0;
  logic        regRd = 1'b0;
  logic [3:0]  regNum = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        invReq;
  logic [18:0] invVpn;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tlb_mirror_regs dut (
    .clk(clk), .rst_n(rst_n), .bankSel(bankSel), .regWe(regWe), .regRd(regRd),
    .regNum(regNum), .wdata(wdata), .rdata(rdata), .invReq(invReq), .invVpn(invVpn)
  );

  // Requirement-level model
  logic [31:0] mS  [4][16];
  logic [31:0] mHi [2][64];
  logic [31:0] mLo [2][64];
  logic        expInv;
  logic [18:0] expVpn;
  logic [31:0] lastRd;

  // Vector: bank[71:70], selector[69:64], high[63:32], low[31:0]
  localparam logic [71:0] VEC [9] = '{
    {2'd1, 6'h00, 32'hAAAA_E000, 32'h0000_0008},
    {2'd2, 6'h00, 32'h1234_6000, 32'h0000_0009},
    {2'd1, 6'h3F, 32'hFFFF_F000, 32'h0000_00F8},
    {2'd1, 6'h00, 32'h5555_4000, 32'h0000_0000},
    {2'd1, 6'h00, 32'h0101_2000, 32'h0000_0008},
    {2'd2, 6'h25, 32'h8000_0000, 32'h0000_0008},
    {2'd2, 6'h00, 32'h0000_0000, 32'h0000_0000},
    {2'd1, 6'h15, 32'hDEAD_E000, 32'h0000_00F7},
    {2'd1, 6'h3F, 32'h0000_0001, 32'h0000_0001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] b, input logic [3:0] r, input logic [31:0] d);
    int t;
    int s;
    @(negedge clk);
    bankSel = b; regNum = r; wdata = d; regWe = 1'b1; regRd = 1'b0;
    expInv = 1'b0;
    mS[b][r] = d;
    if (b == 2'd1 || b == 2'd2) begin
      t = int'(b) - 1;
      s = int'(mS[b][4][5:0]);
      if (r == 4'd6) mS[b][3] = d;
      if (r == 4'd5) begin
        expInv = mLo[t][s][3];
        expVpn = mHi[t][s][31:13];
        mLo[t][s] = d;
        mHi[t][s] = mS[b][3];
      end
    end
    @(negedge clk);
    regWe = 1'b0;
    chk("R6 invReq", 32'(invReq), 32'(expInv));
    if (expInv) begin
      chk("R6 invVpn", 32'(invVpn), 32'(expVpn));
      @(negedge clk);
      chk("R6 pulse width", 32'(invReq), 32'd0);
    end
  endtask

  task automatic rd(input string tag, input logic [1:0] b, input logic [3:0] r);
    int t;
    int s;
    logic [31:0] e;
    @(negedge clk);
    bankSel = b; regNum = r; regRd = 1'b1; regWe = 1'b0;
    if (b == 2'd1 || b == 2'd2) begin
      t = int'(b) - 1;
      s = int'(mS[b][4][5:0]);
      mS[b][5] = mLo[t][s];
      mS[b][6] = mHi[t][s];
    end
    e = mS[b][r];
    @(negedge clk);
    regRd = 1'b0;
    chk(tag, rdata, e);
    lastRd = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) for (int r = 0; r < 16; r++) mS[b][r] = '0;
    for (int t = 0; t < 2; t++) for (int s = 0; s < 64; s++) begin
      mHi[t][s] = '0; mLo[t][s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rdata after reset", rdata, 32'd0);
    chk("R1 invReq after reset", 32'(invReq), 32'd0);
    rd("R1 bank1 entry low", 2'd1, 4'd5);
    rd("R1 bank2 entry high", 2'd2, 4'd6);
    rd("R1 bank0 register", 2'd0, 4'd9);

    // R3 R5 R6: table of load sequences
    for (int v = 0; v < 9; v++) begin
      wr(VEC[v][71:70], 4'd4, {26'd0, VEC[v][69:64]});
      wr(VEC[v][71:70], 4'd6, VEC[v][63:32]);
      wr(VEC[v][71:70], 4'd5, VEC[v][31:0]);
      rd("R5 entry low", VEC[v][71:70], 4'd5);
      rd("R5 entry high", VEC[v][71:70], 4'd6);
      rd("R4 cause copy", VEC[v][71:70], 4'd3);
    end

    // R3: set field separates slots 0x05 and 0x25; banks separate slot 0
    wr(2'd2, 4'd4, 32'h05);
    rd("R3 set discrim", 2'd2, 4'd6);
    wr(2'd2, 4'd4, 32'h25);
    rd("R3 set2 entry5", 2'd2, 4'd6);
    wr(2'd1, 4'd4, 32'h00);
    rd("R3 bank1 slot0", 2'd1, 4'd6);

    // R2: per-bank plain registers
    wr(2'd2, 4'd7, 32'hCAFE_F00D);
    rd("R2 readback", 2'd2, 4'd7);
    rd("R2 other bank", 2'd1, 4'd7);

    // R7: stale mirror value is replaced by the entry on read
    wr(2'd1, 4'd6, 32'h1357_9BDF);
    rd("R7 high refresh", 2'd1, 4'd6);
    wr(2'd1, 4'd4, 32'h3F);
    rd("R7 other entry low", 2'd1, 4'd5);

    // R8: banks 0 and 3 are plain storage
    wr(2'd0, 4'd6, 32'h1111_2222);
    rd("R8 no cause copy", 2'd0, 4'd3);
    wr(2'd0, 4'd5, 32'h0000_0008);
    wr(2'd0, 4'd5, 32'h0000_00FF);
    rd("R8 no refresh low", 2'd0, 4'd5);
    wr(2'd3, 4'd4, 32'h00);
    wr(2'd3, 4'd5, 32'h0000_0008);
    wr(2'd3, 4'd5, 32'h0000_0018);
    rd("R8 bank3 low", 2'd3, 4'd5);
    wr(2'd1, 4'd4, 32'h00);
    rd("R8 TLB untouched", 2'd1, 4'd5);

    // R9: simultaneous write and read, write wins and rdata holds
    @(negedge clk);
    bankSel = 2'd0; regNum = 4'd9; wdata = 32'h0000_0077;
    regWe = 1'b1; regRd = 1'b1;
    mS[0][9] = 32'h0000_0077;
    @(negedge clk);
    regWe = 1'b0; regRd = 1'b0;
    chk("R9 rdata held", rdata, lastRd);
    @(negedge clk);
    chk("R9 rdata still held", rdata, lastRd);
    rd("R9 write done", 2'd0, 4'd9);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule